// File: doc/BRIEF.md
# Serial NAND Cached Page Reader

This block answers host read requests aimed at a serial NAND device. Each request carries a linear byte address and a length. The address splits into a page number (upper bits) and a column inside a 2048-byte page. The block keeps one tag for the page that now sits in the device's internal data buffer. It sends a page-load command only when the requested page differs from that tag, or when the tag is invalid. After a load it polls the device until it is ready.

It then sends a buffer-read command at the column and streams the data bytes out as a byte stream with valid and last flags. A transfer never runs past the end of the page. After every transfer it polls the status register again. The two-bit ECC field of that status is reported with the response. A nonzero ECC result starts a recovery sequence: a device reset, a wait for ready, and a rewrite of the protection and configuration registers. A ready wait that exceeds its cycle budget ends the request with a zero length and a timeout flag.

The device is reached through a byte-exchange port. While `bus_sel` is high, each cycle with `bus_tx_valid` and `bus_tx_ready` both high exchanges one byte. `bus_rx_data` is the byte received in that exchange. A command lasts exactly one select window.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, `req_ready` is high, and `bus_sel`, `out_valid` and `resp_valid` are low. The page tag is invalid, so the first request always loads its page.
- R2: A page load is the four bytes 0x13, 0x00, page[15:8], page[7:0], where page = address / 2048. It is sent only when the tag is invalid or differs from the requested page. A hit goes straight to the buffer read.
- R3: The tag is invalid from the moment a page load starts. It takes the requested page only when the poll after that load reports ready.
- R4: A buffer read is the bytes 0x03, column[15:8], column[7:0], 0x00, followed by one exchange per data byte. Each received data byte appears on `out_data` with `out_valid`, in column order, and `out_last` marks the final byte.
- R5: The number of data bytes is min(length, 2048 - column), where column = address mod 2048. A zero length produces no data bytes and a response length of 0.
- R6: A status poll is the bytes 0x05, 0xC0, 0x00, and the third received byte is the status. Bit 0 set means busy, and the poll repeats in a new select window while it is set. After a transfer, status bits [5:4] are returned on `resp_ecc` (0 clean, 1 corrected, 2 one page uncorrectable, 3 several pages uncorrectable).
- R7: A nonzero ECC result invalidates the tag, sends 0xFF, and polls until ready. It then writes register 0xA0 with 0x00 and register 0xB0 with 0x18, each as the bytes 0x01, register, value.
- R8: A ready wait after a load or a read is limited to LOAD_TMO_CYC cycles, and one after a device reset to RESET_TMO_CYC cycles. On expiry the response has `resp_len` = 0 and `resp_tmo` = 1, and the tag is invalid.
- R9: Every accepted request gets exactly one single-cycle `resp_valid` pulse. `req_ready` stays low from acceptance until that pulse.
- R10: `bus_sel` goes low for at least one cycle after the last byte of every command, so each command has a select window of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | ADDR_W | Linear byte address |
| req_len | input | LEN_W | Requested byte count |
| bus_sel | output | 1 | Device select, high for the whole command |
| bus_tx_valid | output | 1 | Byte offered for exchange |
| bus_tx_data | output | 8 | Byte sent to the device |
| bus_tx_ready | input | 1 | Exchange happens this cycle |
| bus_rx_data | input | 8 | Byte received in the exchange |
| out_valid | output | 1 | Data byte valid |
| out_data | output | 8 | Data byte |
| out_last | output | 1 | Final data byte of the transfer |
| resp_valid | output | 1 | Response pulse |
| resp_len | output | LEN_W | Bytes actually transferred, 0 on timeout |
| resp_ecc | output | 2 | ECC result of the transfer |
| resp_tmo | output | 1 | A ready wait timed out |

## Verification
The embedded assertions watch the properties that hold on every cycle. The tag stays invalid while a load wait is in progress. Responses are single pulses, and no data byte appears while the block is idle. A timed-out response always carries a zero length, and a nonzero ECC response leaves the tag invalid. The select line also drops after every final byte. What only the bench scenarios can show is the exact command bytes and their order, including the page and column fields. The bench scenarios also cover whether a hit really skips the load, the clipping and data order at the page end, the recovery register writes, and the timeouts against a device model that never becomes ready.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP, ST_RESP} st_e;

  // command phases of one request
  typedef enum logic [2:0] {
    PH_LOAD, PH_LWAIT, PH_READ, PH_RWAIT,
    PH_RST, PH_XWAIT, PH_WPROT, PH_WCONF
  } ph_e;

  localparam logic [7:0] OP_LOAD  = 8'h13;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WREG  = 8'h01;
  localparam logic [7:0] OP_RESET = 8'hFF;
  localparam logic [7:0] REG_STAT = 8'hC0;
  localparam logic [7:0] REG_CONF = 8'hB0;
  localparam logic [7:0] REG_PROT = 8'hA0;
  localparam logic [7:0] CONF_VAL = 8'h18;

  function automatic logic is_poll(ph_e p);
    return (p == PH_LWAIT) || (p == PH_RWAIT) || (p == PH_XWAIT);
  endfunction

endpackage

// File: rtl/nand_rd_split.sv
module nand_rd_split #(
  parameter int ADDR_W     = 27,
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 2048,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic [15:0]       page,
  output logic [COL_W-1:0]  col,
  output logic [LEN_W-1:0]  xlen
);
  logic [LEN_W:0] room;

  assign page = 16'(addr >> COL_W);
  assign col  = addr[COL_W-1:0];
  assign room = (LEN_W+1)'(PAGE_BYTES) - (LEN_W+1)'(col);
  assign xlen = ({1'b0, len} < room) ? len : LEN_W'(room);
endmodule

// File: rtl/nand_rd_timer.sv
module nand_rd_timer #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_q;

  assign expired = (cnt >= lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lim_q <= '0;
    end else if (start) begin
      cnt   <= '0;
      lim_q <= limit;
    end else if (!expired) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int ADDR_W        = 27,
  parameter int LEN_W         = 12,
  parameter int PAGE_BYTES    = 2048,
  parameter int LOAD_TMO_CYC  = 250000,
  parameter int RESET_TMO_CYC = 62500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              bus_sel,
  output logic              bus_tx_valid,
  output logic [7:0]        bus_tx_data,
  input  logic              bus_tx_ready,
  input  logic [7:0]        bus_rx_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              resp_valid,
  output logic [LEN_W-1:0]  resp_len,
  output logic [1:0]        resp_ecc,
  output logic              resp_tmo
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int IDX_W = LEN_W + 1;
  localparam int TMR_W = $clog2(RESET_TMO_CYC + 1);

  st_e              state;
  ph_e              phase;
  logic [IDX_W-1:0] idx, last_idx;
  logic             cache_valid;
  logic [15:0]      cache_page, page_q, sp_page;
  logic [COL_W-1:0] col_q, sp_col;
  logic [LEN_W-1:0] xlen_q, sp_xlen;
  logic             busy_q, tmo_q;
  logic [1:0]       ecc_rx, ecc_q;
  logic             tmr_start, tmr_exp;
  logic [TMR_W-1:0] tmr_limit;
  logic [15:0]      col16;

  nand_rd_split #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_split (
    .addr(req_addr), .len(req_len), .page(sp_page), .col(sp_col), .xlen(sp_xlen));

  assign tmr_start = (state == ST_GAP) &&
                     ((phase == PH_LOAD) || (phase == PH_READ) || (phase == PH_RST));
  assign tmr_limit = (phase == PH_RST) ? TMR_W'(RESET_TMO_CYC) : TMR_W'(LOAD_TMO_CYC);

  nand_rd_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .limit(tmr_limit), .expired(tmr_exp));

  assign req_ready    = (state == ST_IDLE);
  assign bus_sel      = (state == ST_XFER);
  assign bus_tx_valid = (state == ST_XFER);
  assign col16        = 16'(col_q);

  // byte to send and final byte index of the current command
  always_comb begin
    bus_tx_data = 8'h00;
    last_idx    = IDX_W'(2);
    unique case (phase)
      PH_LOAD: begin
        last_idx = IDX_W'(3);
        case (idx)
          IDX_W'(0): bus_tx_data = OP_LOAD;
          IDX_W'(2): bus_tx_data = page_q[15:8];
          IDX_W'(3): bus_tx_data = page_q[7:0];
          default:   bus_tx_data = 8'h00;
        endcase
      end
      PH_READ: begin
        last_idx = IDX_W'(3) + IDX_W'(xlen_q);
        case (idx)
          IDX_W'(0): bus_tx_data = OP_READ;
          IDX_W'(1): bus_tx_data = col16[15:8];
          IDX_W'(2): bus_tx_data = col16[7:0];
          default:   bus_tx_data = 8'h00;
        endcase
      end
      PH_RST: begin
        last_idx    = IDX_W'(0);
        bus_tx_data = OP_RESET;
      end
      PH_WPROT, PH_WCONF: begin
        case (idx)
          IDX_W'(0): bus_tx_data = OP_WREG;
          IDX_W'(1): bus_tx_data = (phase == PH_WPROT) ? REG_PROT : REG_CONF;
          default:   bus_tx_data = (phase == PH_WPROT) ? 8'h00 : CONF_VAL;
        endcase
      end
      default: begin
        case (idx)
          IDX_W'(0): bus_tx_data = OP_STAT;
          IDX_W'(1): bus_tx_data = REG_STAT;
          default:   bus_tx_data = 8'h00;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;     phase <= PH_LOAD;   idx <= '0;
      cache_valid <= 1'b0;  cache_page <= '0;
      page_q <= '0;         col_q <= '0;        xlen_q <= '0;
      busy_q <= 1'b0;       ecc_rx <= '0;       ecc_q <= '0;  tmo_q <= 1'b0;
      out_valid <= 1'b0;    out_data <= '0;     out_last <= 1'b0;
      resp_valid <= 1'b0;   resp_len <= '0;     resp_ecc <= '0; resp_tmo <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          page_q <= sp_page;  col_q <= sp_col;  xlen_q <= sp_xlen;
          ecc_q  <= '0;       tmo_q <= 1'b0;    idx <= '0;
          state  <= ST_XFER;
          if (cache_valid && cache_page == sp_page) begin
            phase <= PH_READ;
          end else begin
            phase       <= PH_LOAD;
            cache_valid <= 1'b0;
          end
        end
        ST_XFER: if (bus_tx_ready) begin
          if (phase == PH_READ && idx > IDX_W'(3)) begin
            out_valid <= 1'b1;
            out_data  <= bus_rx_data;
            out_last  <= (idx == last_idx);
          end
          if (is_poll(phase) && idx == IDX_W'(2)) begin
            busy_q <= bus_rx_data[0];
            ecc_rx <= bus_rx_data[5:4];
          end
          if (idx == last_idx) state <= ST_GAP;
          else                 idx   <= idx + 1'b1;
        end
        ST_GAP: begin
          idx   <= '0;
          state <= ST_XFER;
          unique case (phase)
            PH_LOAD:  phase <= PH_LWAIT;
            PH_READ:  phase <= PH_RWAIT;
            PH_RST:   phase <= PH_XWAIT;
            PH_WPROT: phase <= PH_WCONF;
            PH_WCONF: state <= ST_RESP;
            default: begin
              if (busy_q) begin
                if (tmr_exp) begin
                  tmo_q       <= 1'b1;
                  cache_valid <= 1'b0;
                  state       <= ST_RESP;
                end
              end else if (phase == PH_LWAIT) begin
                cache_valid <= 1'b1;
                cache_page  <= page_q;
                phase       <= PH_READ;
              end else if (phase == PH_RWAIT) begin
                ecc_q <= ecc_rx;
                if (ecc_rx != 2'd0) begin
                  cache_valid <= 1'b0;
                  phase       <= PH_RST;
                end else begin
                  state <= ST_RESP;
                end
              end else begin
                phase <= PH_WPROT;
              end
            end
          endcase
        end
        default: begin
          resp_valid <= 1'b1;
          resp_len   <= tmo_q ? '0 : xlen_q;
          resp_ecc   <= ecc_q;
          resp_tmo   <= tmo_q;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  // R3: the tag stays invalid while a load wait is polling
  a_r3_tag_invalid_in_load: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && phase == PH_LWAIT) |-> !cache_valid);
  // R4: last flag only with a data byte
  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R5: reported length never exceeds a page
  a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_len <= LEN_W'(PAGE_BYTES)));
  // R7: an ECC failure leaves the tag invalid
  a_r7_ecc_drops_tag: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_ecc != 2'd0) |-> !cache_valid);
  // R8: a timeout always reports zero bytes
  a_r8_tmo_zero_len: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_tmo) |-> (resp_len == '0));
  // R9: single-cycle response, no data while idle
  a_r9_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  a_r9_no_data_idle: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);
  // R10: select drops after the final byte of a command
  a_r10_sel_gap: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_tx_ready && idx == last_idx) |=> !bus_sel);
endmodule

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;
  localparam int ADDR_W = 27;
  localparam int LEN_W  = 12;
  localparam int PB     = 2048;
  localparam int NEVER  = 1000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              bus_sel, bus_tx_valid, bus_tx_ready = 1'b1;
  logic [7:0]        bus_tx_data, bus_rx_data;
  logic              out_valid, out_last, resp_valid, resp_tmo;
  logic [7:0]        out_data;
  logic [LEN_W-1:0]  resp_len;
  logic [1:0]        resp_ecc;

  nand_page_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PB),
                     .LOAD_TMO_CYC(300), .RESET_TMO_CYC(700)) u_dut (
    .clk, .rst, .req_valid, .req_ready, .req_addr, .req_len,
    .bus_sel, .bus_tx_valid, .bus_tx_data, .bus_tx_ready, .bus_rx_data,
    .out_valid, .out_data, .out_last, .resp_valid, .resp_len, .resp_ecc, .resp_tmo);

  int checks = 0, errors = 0;

  function automatic logic [7:0] pat(int page, int col);
    return 8'(page * 13 + col * 7 + 90);
  endfunction

  // device model knobs (driven only by the main initial block)
  int load_busy = 2, rst_busy = 1;
  logic [1:0] ecc_inject = 2'd0;

  // device model state
  logic [7:0] c0, c1, c2, c3, prot_val, conf_val;
  int dn, busy_left, dpage, loads, resets, wrs, bad_cmds;
  logic psel;
  logic [1:0] ecc_cur;

  always_comb begin
    bus_rx_data = 8'h00;
    if (dn == 2 && c0 == 8'h05)
      bus_rx_data = {2'b00, ecc_cur, 3'b000, busy_left != 0};
    else if (dn >= 4 && c0 == 8'h03)
      bus_rx_data = pat(dpage, int'({c1, c2}) + dn - 4);
  end

  always @(posedge clk) begin
    if (rst) begin
      dn <= 0; psel <= 1'b0; busy_left <= 0; ecc_cur <= 2'd0; dpage <= -1;
      loads <= 0; resets <= 0; wrs <= 0; bad_cmds <= 0;
      prot_val <= 8'hEE; conf_val <= 8'h00;
      c0 <= 8'h00; c1 <= 8'h00; c2 <= 8'h00; c3 <= 8'h00;
    end else begin
      psel <= bus_sel;
      if (bus_sel && bus_tx_valid && bus_tx_ready) begin
        if (dn == 0) c0 <= bus_tx_data;
        if (dn == 1) c1 <= bus_tx_data;
        if (dn == 2) c2 <= bus_tx_data;
        if (dn == 3) c3 <= bus_tx_data;
        if (dn == 2 && c0 == 8'h05 && busy_left > 0 && busy_left < NEVER) busy_left <= busy_left - 1;
        dn <= dn + 1;
      end
      if (!bus_sel && psel) begin
        dn <= 0;
        case (c0)
          8'h13: begin
            if (dn != 4 || c1 != 8'h00) bad_cmds <= bad_cmds + 1;
            busy_left <= load_busy; dpage <= int'({c2, c3}); loads <= loads + 1;
          end
          8'h03: ecc_cur <= ecc_inject;
          8'hFF: begin
            if (dn != 1) bad_cmds <= bad_cmds + 1;
            busy_left <= rst_busy; ecc_cur <= 2'd0; resets <= resets + 1;
          end
          8'h01: begin
            wrs <= wrs + 1;
            if (c1 == 8'hA0) prot_val <= c2;
            else if (c1 == 8'hB0) conf_val <= c2;
            else bad_cmds <= bad_cmds + 1;
          end
          8'h05: if (dn != 3 || c1 != 8'hC0) bad_cmds <= bad_cmds + 1;
          default: bad_cmds <= bad_cmds + 1;
        endcase
      end
    end
  end

  always @(negedge clk) bus_tx_ready <= ($urandom % 4) != 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench reference of the page tag
  logic ref_valid = 1'b0;
  int   ref_page  = 0;

  task automatic do_req(input int addr, input int len, input logic [1:0] e,
                        input int lb, input int rb);
    int page = addr / PB;
    int col  = addr % PB;
    int xl   = (len < PB - col) ? len : PB - col;
    logic need = !ref_valid || ref_page != page;
    logic tl   = need && lb >= NEVER;
    logic tr   = !tl && e != 0 && rb >= NEVER;
    int exp_len   = (tl || tr) ? 0 : xl;
    int exp_beats = tl ? 0 : xl;
    int exp_ecc   = tl ? 0 : int'(e);
    int l0 = loads, r0 = resets, w0 = wrs;
    int beats = 0, derr = 0, lasterr = 0, wait_cyc = 0;
    logic got = 1'b0, rdy_err = 1'b0;
    int g_len = 0, g_ecc = 0;
    logic g_tmo = 1'b0;
    load_busy = lb; rst_busy = rb; ecc_inject = e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_valid = 1'b1;
    while (!got && wait_cyc < 20000) begin
      @(negedge clk);
      wait_cyc++;
      if (req_valid) req_valid = 1'b0;
      if (req_ready && !resp_valid) rdy_err = 1'b1;
      if (out_valid) begin
        if (out_data != pat(page, col + beats)) derr++;
        if (out_last != (beats == xl - 1)) lasterr++;
        beats++;
      end
      if (resp_valid) begin
        got = 1'b1; g_len = int'(resp_len); g_ecc = int'(resp_ecc); g_tmo = resp_tmo;
      end
    end
    chk(got, "R9 response arrives", int'(got), 1);
    chk(!rdy_err, "R9 req_ready low while serving", int'(rdy_err), 0);
    @(negedge clk);
    chk(!resp_valid, "R9 single-cycle response", int'(resp_valid), 0);
    chk(g_len == exp_len, "R5/R8 resp_len", g_len, exp_len);
    chk(beats == exp_beats, "R5 data byte count", beats, exp_beats);
    chk(derr == 0, "R4 data bytes in column order", derr, 0);
    chk(lasterr == 0, "R4 out_last on final byte only", lasterr, 0);
    chk(g_ecc == exp_ecc, "R6 resp_ecc", g_ecc, exp_ecc);
    chk(g_tmo == (tl || tr), "R8 resp_tmo", int'(g_tmo), int'(tl || tr));
    chk(loads - l0 == int'(need), "R2 load only on miss", loads - l0, int'(need));
    if (need) chk(dpage == page, "R2 load page field", dpage, page);
    chk(resets - r0 == int'(!tl && e != 0), "R7 reset on ECC", resets - r0, int'(!tl && e != 0));
    if (!tl && !tr && e != 0) begin
      chk(wrs - w0 == 2, "R7 two register writes", wrs - w0, 2);
      chk(prot_val == 8'h00, "R7 protection register", int'(prot_val), 0);
      chk(conf_val == 8'h18, "R7 configuration register", int'(conf_val), 24);
    end
    chk(bad_cmds == 0, "R10 command framing", bad_cmds, 0);
    ref_valid = !tl && !tr && e == 0;
    ref_page  = page;
    ecc_inject = 2'd0; load_busy = 2; rst_busy = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired (R9) actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !bus_sel && !out_valid && !resp_valid, "R1 reset state",
        int'({req_ready, bus_sel, out_valid, resp_valid}), 8);
    do_req(5 * PB + 100, 16, 2'd0, 2, 1);     // R2 R3 first miss
    do_req(5 * PB + 2040, 30, 2'd0, 2, 1);    // R5 clip at page end, hit
    do_req(5 * PB + 7, 0, 2'd0, 2, 1);        // R5 zero length on a hit
    do_req(9 * PB, 4095, 2'd0, 6, 1);         // R5 full page, R6 several busy polls
    do_req(9 * PB + 3, 5, 2'd1, 2, 1);        // R7 corrected ECC on a hit
    do_req(9 * PB + 3, 5, 2'd0, 2, 1);        // R3 reload after recovery
    do_req(2 * PB + 1000, 40, 2'd3, 2, 4);    // R6 R7 multi-page ECC
    do_req(7 * PB, 10, 2'd0, NEVER, 1);       // R8 load timeout
    do_req(7 * PB, 10, 2'd0, 2, 1);           // R3 tag stayed invalid
    do_req(7 * PB + 20, 8, 2'd2, 2, NEVER);   // R8 reset wait timeout
    do_req(7 * PB + 20, 8, 2'd0, 0, 1);       // R2 reload after that
    for (int i = 0; i < 40; i++) begin
      int pg = (i % 3 == 0) ? 3 : ((i % 3 == 1) ? 4 : 11);
      int ad = pg * PB + int'($urandom % PB);
      int ln = ($urandom % 8 == 0) ? int'($urandom % 4096) : int'($urandom % 300);
      logic [1:0] ee = ($urandom % 8 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      do_req(ad, ln, ee, int'($urandom % 4), 1 + int'($urandom % 3));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule